// File: doc/BRIEF.md
# Drive Power Mode Manager

This block is the power-state controller of a small disk drive. After power-on reset it samples a slot-type select input once. A slot that does not expect this kind of drive locks the block in deep sleep, and only another power-on reset releases it. Otherwise the block runs a long initial spin-up and becomes active. From then on the host steers it with single-byte opcodes. Some opcodes force standby or active, and some do so while also programming an inactivity timer. One opcode queries the mode and one enters sleep. Disk accesses reload the timer, and an access in standby wakes the drive. The spindle and servo are not modelled: each spin-up is a fixed delay derived from a parameterized tick rate.

Commands and disk accesses arrive over two valid/ready channels. A command is taken on any cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is low only in the power-on sampling cycle. A disk access is taken only while the drive is active. An access in standby or during spin-up is back-pressured: `acc_ready` stays low, and the requester must hold `acc_valid` and its request until the handshake. The query answer is returned as a one-cycle `sc_valid` pulse carrying the sector-count byte, with no back-pressure. The other outputs are plain status pins.

The rates are set by `TICKS_PER_SEC`. One timer unit is 5 s, which is `5*TICKS_PER_SEC` cycles. The first spin-up lasts 5 s and every later spin-up lasts 1.5 s (`3*TICKS_PER_SEC/2` cycles).

Top module: `pwr_mode_mgr`

## Requirements
- R1: `mode` encodes the states as follows: 0 power-on, 1 deep sleep, 2 sleep, 3 standby, 4 spinning up, 5 active. On the first clock edge after `rst_n` is released, `slot_sel_n` is sampled. If it is high the mode becomes 1. If it is low the mode becomes 4 and then 5 exactly `5*TICKS_PER_SEC` edges later. `busy` is high in modes 0 and 4 only.
- R2: In deep sleep, commands, disk accesses and `soft_rst` have no effect. `mode`, `busy`, `acc_ready` and `sc_valid` stay unchanged until `rst_n` is asserted.
- R3: Opcode 0xE0 or 0xE2, accepted in active or spinning-up mode, gives standby on the next edge. In standby it keeps the drive in standby.
- R4: Opcode 0xE1 or 0xE3, accepted in standby, starts a spin-up (mode 4). The drive becomes active `3*TICKS_PER_SEC/2` edges later. In active or spinning-up mode these opcodes leave the mode unchanged.
- R5: When opcode 0xE2 or 0xE3 is accepted, a `cmd_count` of zero disables the inactivity timer. A nonzero `cmd_count` of N enables it with a period of N units of `5*TICKS_PER_SEC` cycles. The timer is disabled after power-on.
- R6: While the drive is active and the timer is enabled, the drive enters standby exactly N units after the last reload. A reload happens on entering active, on every accepted disk access, and on 0xE2/0xE3 accepted while active.
- R7: `acc_ready` is high only in active mode. `acc_valid` seen in standby starts a short spin-up, and the access is then accepted on the first active cycle.
- R8: Opcode 0xE5, accepted in standby, spinning-up or active mode, yields `sc_valid` high for one cycle on the next edge. `sc_data` is 0xFF if the drive was active when the command was accepted, and 0x00 otherwise.
- R9: Opcode 0xE6, accepted in standby, spinning-up or active mode, enters sleep. In sleep, commands and accesses are ignored, and a `soft_rst` pulse moves the drive to standby on the next edge.
- R10: A command outranks a simultaneous disk access or timer expiry. Opcodes other than 0xE0–0xE3, 0xE5 and 0xE6 are accepted and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst | input | 1 | Host hardware or software reset pulse |
| slot_sel_n | input | 1 | Slot-type select, active low, sampled once after power-on |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 8 | Command opcode |
| cmd_count | input | 8 | Sector-count byte sent with the command |
| acc_valid | input | 1 | Disk access requested |
| acc_ready | output | 1 | Disk access taken (active mode only) |
| mode | output | 3 | Current power mode code |
| busy | output | 1 | Power-on sampling or spin-up in progress |
| sc_valid | output | 1 | Query answer valid, one cycle |
| sc_data | output | 8 | Query answer, sector-count byte |

## Verification
Every result appears a fixed number of edges after its cause. A mode change and the query pulse arrive on the edge that accepts the command. A spin-up ends exactly its length in edges after it starts, and a timer expiry lands exactly N units after the last reload. A behavioural model in the bench advances on each rising edge from the same inputs and counts these delays as plain remaining-cycle integers. All outputs are registered, so the bench compares every output with the model on each falling edge, and any off-by-one in a delay shows up in the first cycle it affects. Directed checks also sample the mode one edge before and one edge after the spin-up boundary.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    PM_POR   = 3'd0,
    PM_DEEP  = 3'd1,
    PM_SLEEP = 3'd2,
    PM_STBY  = 3'd3,
    PM_SPIN  = 3'd4,
    PM_ACT   = 3'd5
  } pm_mode_e;

  localparam logic [7:0] OP_STBY_NOW = 8'hE0;
  localparam logic [7:0] OP_ACT_NOW  = 8'hE1;
  localparam logic [7:0] OP_STBY_TMR = 8'hE2;
  localparam logic [7:0] OP_ACT_TMR  = 8'hE3;
  localparam logic [7:0] OP_QUERY    = 8'hE5;
  localparam logic [7:0] OP_SLEEP    = 8'hE6;
endpackage

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
  parameter int UNIT_TICKS = 100,
  parameter int CW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          reload,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  localparam int PW = (UNIT_TICKS > 2) ? $clog2(UNIT_TICKS) : 1;

  logic [PW-1:0] pre_q;
  logic [CW-1:0] units_q;
  logic          unit_end;

  assign unit_end = (pre_q == PW'(UNIT_TICKS - 1));
  assign expire   = run && unit_end && (units_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (reload) begin
      pre_q   <= '0;
      units_q <= load_val;
    end else if (run) begin
      if (unit_end) begin
        pre_q <= '0;
        if (units_q != CW'(1)) units_q <= units_q - CW'(1);
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

  // R6
  units_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (units_q != '0));
endmodule

// File: rtl/pm_spinup.sv
module pm_spinup #(
  parameter int LONG_T  = 100,
  parameter int SHORT_T = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(LONG_T + 1);

  logic [CW-1:0] cnt_q;

  assign done = en && !start && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (start)               cnt_q <= long_sel ? CW'(LONG_T - 1) : CW'(SHORT_T - 1);
    else if (en && cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/pwr_mode_mgr.sv
module pwr_mode_mgr #(
  parameter int TICKS_PER_SEC = 20,
  parameter int UNIT_SEC      = 5,
  parameter int CNT_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             slot_sel_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_op,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             acc_valid,
  output logic             acc_ready,
  output logic [2:0]       mode,
  output logic             busy,
  output logic             sc_valid,
  output logic [CNT_W-1:0] sc_data
);
  import pwr_mode_pkg::*;

  localparam int UNIT_TICKS = UNIT_SEC * TICKS_PER_SEC;
  localparam int LONG_T     = 5 * TICKS_PER_SEC;
  localparam int SHORT_T    = (3 * TICKS_PER_SEC) / 2;

  pm_mode_e mode_q, mode_d;
  logic tmr_en_q;
  logic [CNT_W-1:0] tmr_val_q, load_val;
  logic sc_valid_q;
  logic [CNT_W-1:0] sc_data_q;

  logic live, use_cmd, is_std, is_act, is_tmr, is_qry, is_slp;
  logic acc_fire, spin_start, spin_long, spin_done;
  logic enter_act, reload, run, expire;

  assign cmd_ready = (mode_q != PM_POR);
  assign acc_ready = (mode_q == PM_ACT);
  assign acc_fire  = acc_valid && acc_ready;
  assign live      = (mode_q == PM_STBY) || (mode_q == PM_SPIN) || (mode_q == PM_ACT);
  assign use_cmd   = cmd_valid && cmd_ready && live;
  assign is_std    = use_cmd && (cmd_op == OP_STBY_NOW || cmd_op == OP_STBY_TMR);
  assign is_act    = use_cmd && (cmd_op == OP_ACT_NOW  || cmd_op == OP_ACT_TMR);
  assign is_tmr    = use_cmd && (cmd_op == OP_STBY_TMR || cmd_op == OP_ACT_TMR);
  assign is_qry    = use_cmd && (cmd_op == OP_QUERY);
  assign is_slp    = use_cmd && (cmd_op == OP_SLEEP);

  always_comb begin
    mode_d     = mode_q;
    spin_start = 1'b0;
    spin_long  = 1'b0;
    unique case (mode_q)
      PM_POR: begin
        if (slot_sel_n) mode_d = PM_DEEP;
        else begin
          mode_d     = PM_SPIN;
          spin_start = 1'b1;
          spin_long  = 1'b1;
        end
      end
      PM_DEEP:  mode_d = PM_DEEP;
      PM_SLEEP: if (soft_rst) mode_d = PM_STBY;
      PM_STBY: begin
        if (is_slp) mode_d = PM_SLEEP;
        else if (is_act || (acc_valid && !is_std)) begin
          mode_d     = PM_SPIN;
          spin_start = 1'b1;
        end
      end
      PM_SPIN: begin
        if (is_slp)         mode_d = PM_SLEEP;
        else if (is_std)    mode_d = PM_STBY;
        else if (spin_done) mode_d = PM_ACT;
      end
      PM_ACT: begin
        if (is_slp)         mode_d = PM_SLEEP;
        else if (is_std)    mode_d = PM_STBY;
        else if (expire)    mode_d = PM_STBY;
      end
      default: mode_d = PM_POR;
    endcase
  end

  assign load_val  = is_tmr ? cmd_count : tmr_val_q;
  assign enter_act = (mode_d == PM_ACT) && (mode_q != PM_ACT);
  assign reload    = acc_fire || enter_act || ((mode_q == PM_ACT) && is_tmr);
  assign run       = (mode_q == PM_ACT) && tmr_en_q && !reload;

  pm_idle_timer #(.UNIT_TICKS(UNIT_TICKS), .CW(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .reload(reload),
    .load_val(load_val), .expire(expire)
  );

  pm_spinup #(.LONG_T(LONG_T), .SHORT_T(SHORT_T)) u_spin (
    .clk(clk), .rst_n(rst_n), .start(spin_start), .long_sel(spin_long),
    .en(mode_q == PM_SPIN), .done(spin_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= PM_POR;
      tmr_en_q   <= 1'b0;
      tmr_val_q  <= '0;
      sc_valid_q <= 1'b0;
      sc_data_q  <= '0;
    end else begin
      mode_q     <= mode_d;
      sc_valid_q <= is_qry;
      if (is_qry) sc_data_q <= (mode_q == PM_ACT) ? '1 : '0;
      if (is_tmr) begin
        tmr_en_q  <= (cmd_count != '0);
        tmr_val_q <= cmd_count;
      end
    end
  end

  assign mode     = mode_q;
  assign busy     = (mode_q == PM_POR) || (mode_q == PM_SPIN);
  assign sc_valid = sc_valid_q;
  assign sc_data  = sc_data_q;

  // R2
  deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_DEEP) |=> (mode_q == PM_DEEP));
  // R9
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_SLEEP && !soft_rst) |=> (mode_q == PM_SLEEP));
  // R9
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_SLEEP && soft_rst) |=> (mode_q == PM_STBY));
  // R7
  wake_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_STBY) |=> (mode_q == PM_STBY || mode_q == PM_SPIN || mode_q == PM_SLEEP));
  // R1
  act_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_ACT && $past(mode_q) != PM_ACT) |-> ($past(mode_q) == PM_SPIN));
  // R8
  query_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid |-> (sc_data == '1 || sc_data == '0));
endmodule

// File: tb/pwr_mode_mgr_tb.sv
module pwr_mode_mgr_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TPS   = 20;
  localparam int UNIT  = 5 * TPS;
  localparam int LONGC = 5 * TPS;
  localparam int SHRT  = (3 * TPS) / 2;

  logic clk = 0, rst_n = 0, soft_rst = 0, slot_sel_n = 1;
  logic cmd_valid = 0, acc_valid = 0;
  logic [7:0] cmd_op = 0, cmd_count = 0;
  logic cmd_ready, acc_ready, busy, sc_valid;
  logic [2:0] mode;
  logic [7:0] sc_data;

  int checks = 0, fails = 0, cyc = 0;
  bit done_flag = 0;
  string cur_req = "R1";

  pwr_mode_mgr #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .slot_sel_n(slot_sel_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_count(cmd_count),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .mode(mode), .busy(busy),
    .sc_valid(sc_valid), .sc_data(sc_data)
  );

  always #2.5ns clk = ~clk;

  // behavioural reference model
  int m_mode, m_spin, m_rem, m_val, nm, nval;
  bit m_en, m_scv, nen, cf, af, std, act, tmr, qry, slp, rld, expd;
  logic [7:0] m_scd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_spin = 0; m_rem = 0; m_val = 0; m_en = 0; m_scv = 0; m_scd = 0;
    end else begin
      cf  = cmd_valid && m_mode != 0 && (m_mode == 3 || m_mode == 4 || m_mode == 5);
      af  = acc_valid && m_mode == 5;
      std = cf && (cmd_op == 8'hE0 || cmd_op == 8'hE2);
      act = cf && (cmd_op == 8'hE1 || cmd_op == 8'hE3);
      tmr = cf && (cmd_op == 8'hE2 || cmd_op == 8'hE3);
      qry = cf && cmd_op == 8'hE5;
      slp = cf && cmd_op == 8'hE6;
      nen = tmr ? (cmd_count != 0) : m_en;
      nval = tmr ? int'(cmd_count) : m_val;
      rld = af || (m_mode == 5 && tmr);
      expd = (m_mode == 5) && m_en && !rld && m_rem == 1;
      nm = m_mode;
      case (m_mode)
        0: if (slot_sel_n) nm = 1; else begin nm = 4; m_spin = LONGC; end
        2: if (soft_rst) nm = 3;
        3: if (slp) nm = 2;
           else if (act || (acc_valid && !std)) begin nm = 4; m_spin = SHRT; end
        4: if (slp) nm = 2; else if (std) nm = 3;
           else if (m_spin == 1) nm = 5; else m_spin--;
        5: if (slp) nm = 2; else if (std || expd) nm = 3;
        default: ;
      endcase
      if (nm == 5 && m_mode != 5) rld = 1;
      if (rld) m_rem = nval * UNIT;
      else if (m_mode == 5 && m_en && m_rem > 1) m_rem--;
      m_scv = qry;
      if (qry) m_scd = (m_mode == 5) ? 8'hFF : 8'h00;
      m_en = nen; m_val = nval; m_mode = nm;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      checks++;
      if (mode !== 3'(m_mode) || busy !== (m_mode == 0 || m_mode == 4) ||
          acc_ready !== (m_mode == 5) || cmd_ready !== (m_mode != 0) ||
          sc_valid !== m_scv || (m_scv && sc_data !== m_scd)) begin
        fails++;
        $display("FAIL %s cyc=%0d mode act=%0d exp=%0d busy=%0b acc_rdy=%0b sc_v act=%0b exp=%0b sc_d act=%h exp=%h",
                 cur_req, cyc, mode, m_mode, busy, acc_ready, sc_valid, m_scv, sc_data, m_scd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] op, input logic [7:0] cnt);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_count = cnt;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic expect_mode(input int exp, input string tag);
    checks++;
    if (mode !== 3'(exp)) begin
      fails++;
      $display("FAIL %s mode act=%0d exp=%0d", tag, mode, exp);
    end
  endtask

  task automatic access_wait();
    acc_valid = 1;
    do @(negedge clk); while (!acc_ready);
    @(negedge clk);
    acc_valid = 0;
  endtask

  initial begin
    // R2: slot high at power-on -> deep sleep, nothing wakes it
    cur_req = "R2";
    tick(3);
    rst_n = 1;
    tick(1);
    expect_mode(1, "R1");
    send(8'hE1, 0);
    acc_valid = 1; tick(4); acc_valid = 0;
    soft_rst = 1; tick(1); soft_rst = 0;
    send(8'hE5, 0);
    tick(5);
    expect_mode(1, "R2");

    // R1: power cycle with slot low -> long spin-up
    cur_req = "R1";
    rst_n = 0; slot_sel_n = 0;
    tick(2);
    rst_n = 1;
    tick(LONGC);
    expect_mode(4, "R1");
    tick(1);
    expect_mode(5, "R1");

    // R8: query while active
    cur_req = "R8";
    send(8'hE5, 0);
    tick(2);

    // R5/R6: timer of one unit, access reload, then expiry
    cur_req = "R6";
    send(8'hE3, 1);
    tick(50);
    acc_valid = 1; tick(1); acc_valid = 0;
    tick(UNIT + 5);
    expect_mode(3, "R6");

    // R8: query in standby
    cur_req = "R8";
    send(8'hE5, 0);

    // R7: access in standby wakes, held until ready; query during spin-up
    cur_req = "R7";
    fork
      access_wait();
      begin tick(3); send(8'hE5, 0); end
    join
    tick(2);

    // R5: disable timer via zero count; R4: short spin-up
    cur_req = "R5";
    send(8'hE2, 0);
    send(8'hE1, 0);
    cur_req = "R4";
    tick(SHRT + 2);
    expect_mode(5, "R4");
    cur_req = "R5";
    tick(4 * UNIT);
    expect_mode(5, "R5");

    // R3: force standby, then wake
    cur_req = "R3";
    send(8'hE0, 0);
    expect_mode(3, "R3");
    send(8'hE1, 0);
    tick(SHRT + 1);

    // R10: unknown opcode, command beats simultaneous access
    cur_req = "R10";
    send(8'h55, 7);
    expect_mode(5, "R10");
    @(negedge clk);
    cmd_valid = 1; cmd_op = 8'hE0; acc_valid = 1;
    @(negedge clk);
    cmd_valid = 0; acc_valid = 0;
    expect_mode(3, "R10");

    // R5/R6: two-unit timer set from standby, expires after spin-up
    cur_req = "R6";
    send(8'hE3, 2);
    tick(SHRT + 2 * UNIT + 5);
    expect_mode(3, "R6");

    // R9: sleep ignores everything but a reset pulse
    cur_req = "R9";
    send(8'hE1, 0);
    tick(SHRT + 1);
    send(8'hE6, 0);
    send(8'hE1, 0);
    send(8'hE5, 0);
    acc_valid = 1; tick(4); acc_valid = 0;
    expect_mode(2, "R9");
    soft_rst = 1; tick(1); soft_rst = 0;
    expect_mode(3, "R9");
    tick(5);

    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule